// File: doc/BRIEF.md
# Serial ADC Power-Mode Sequencer

This block is the digital control core of a touchscreen-style converter that is driven over a serial link. A host lowers chip-select and clocks in an eight-bit control word, most significant bit first, on the rising edges of the serial clock. The first `1` seen on `din` while the block is idle is the start bit. The last two bits of the word select one of four power modes. The block counts falling serial-clock edges from the start bit. It powers the converter for the conversion window, marks that window with a busy flag, and gates the active-low pen interrupt. It also drives the low-side panel switch that must conduct while the part sleeps.

The mode bits are named here `pd_hi` (seventh bit of the word) and `pd_lo` (eighth bit). When `pd_hi` is 1 the converter stays powered at all times. When it is 0 the converter is powered only during the conversion window. When `pd_lo` is 1 the pen interrupt is masked, and the panel switch is released while asleep. A newly written mode does not take effect until the conversion in flight has finished.

A stand-in result register shifts out the number of completed conversions, so that the frame timing can be seen on `dout`. The serial inputs are sampled on `clk`, which must run at least four times faster than `sclk`.

Top module: `adc_pm_seq`

## Requirements
- R1: While chip-select is low and no frame is open, a rising `sclk` edge with `din`=0 is ignored. A rising edge with `din`=1 opens a frame, and falling edges are counted from there.
- R2: The word is 8 bits, MSB first, with the start bit as bit 1. Bit 7 is `pd_hi` and bit 8 is `pd_lo`. Bits 2 to 6 have no effect on any output.
- R3: `conv_busy` goes high after the 4th falling edge of the frame. It stays high through the 19th and goes low after the 20th.
- R4: With `pd_hi`=0 in force, `conv_en` equals `conv_busy`. The converter is powered for exactly 16 serial clocks, with no added wait.
- R5: With `pd_hi`=1 in force, `conv_en` is high in every cycle.
- R6: A mode carried by a word takes effect after the 20th falling edge of that frame. Until then the previous mode governs all outputs.
- R7: `pen_irq_n` is low only when `pen_touch`=1, `pd_lo`=0 is in force, and `conv_busy`=0. Otherwise it is high.
- R8: `lowside_sw` is high only when the mode in force is `pd_hi`=0, `pd_lo`=0 and `conv_en` is low.
- R9: `cs_n` high closes any open frame and drops `conv_busy` and `dout`. It discards a word whose conversion has not completed and keeps the mode in force.
- R10: After reset the mode is 00, `conv_en`=0, `conv_busy`=0, `dout`=0 and `lowside_sw`=1.
- R11: After falling edges 9 through 20, `dout` carries bits 11 down to 0 of the count of conversions completed before the frame. At all other times it is 0.
- R12: A frame closes after its 24th falling edge, and the next start bit is accepted without toggling chip-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip-select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial control data |
| pen_touch | input | 1 | Raw pen-contact detect from the panel |
| conv_en | output | 1 | Converter power enable |
| conv_busy | output | 1 | Conversion window active |
| pen_irq_n | output | 1 | Active-low pen interrupt |
| lowside_sw | output | 1 | Low-side panel switch on |
| dout | output | 1 | Serial result stand-in |

## Verification
A wrong edge count shifts the busy window, and `conv_en` and `pen_irq_n` show this within one system clock of the offending `sclk` falling edge. A mode register that is committed early or lost shows on `pen_irq_n`, `lowside_sw` and `conv_en` before the 4th falling edge of the next frame. A bad completion counter shows in the next frame's `dout` bits. A failure to close or abort a frame shows as a busy window that does not open on the next word.

// File: rtl/adc_pm_seq.sv
module adc_pm_seq #(
  parameter int WORD_BITS  = 8,
  parameter int CONV_START = 4,
  parameter int CONV_END   = 20,
  parameter int FRAME_LEN  = 24,
  parameter int RES_BITS   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  input  logic pen_touch,
  output logic conv_en,
  output logic conv_busy,
  output logic pen_irq_n,
  output logic lowside_sw,
  output logic dout
);
  localparam int FW = $clog2(FRAME_LEN + 1);
  localparam int WW = $clog2(WORD_BITS + 1);
  localparam logic [FW-1:0] F_START = FW'(CONV_START);
  localparam logic [FW-1:0] F_END   = FW'(CONV_END);
  localparam logic [FW-1:0] F_LOAD  = FW'(CONV_END - RES_BITS);
  localparam logic [FW-1:0] F_FRAME = FW'(FRAME_LEN);
  localparam logic [WW-1:0] W_LAST  = WW'(WORD_BITS - 1);
  localparam logic [WW-1:0] W_FULL  = WW'(WORD_BITS);

  logic                sclk_q, in_frame, busy, prev_din, pend_vld;
  logic [FW-1:0]       fcnt;
  logic [WW-1:0]       rcnt;
  logic [1:0]          mode, pd_pend;
  logic [RES_BITS-1:0] shreg, done_cnt;

  wire rise  = sclk & ~sclk_q;
  wire fall  = ~sclk & sclk_q;
  wire [FW-1:0] fnext = fcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      in_frame <= 1'b0;
      busy     <= 1'b0;
      prev_din <= 1'b0;
      pend_vld <= 1'b0;
      fcnt     <= '0;
      rcnt     <= '0;
      mode     <= 2'b00;
      pd_pend  <= 2'b00;
      shreg    <= '0;
      done_cnt <= '0;
      dout     <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        in_frame <= 1'b0;
        busy     <= 1'b0;
        pend_vld <= 1'b0;
        fcnt     <= '0;
        rcnt     <= '0;
        dout     <= 1'b0;
      end else begin
        if (rise) begin
          if (!in_frame) begin
            if (din) begin
              in_frame <= 1'b1;
              rcnt     <= WW'(1);
              fcnt     <= '0;
              prev_din <= din;
            end
          end else if (rcnt < W_FULL) begin
            rcnt     <= rcnt + 1'b1;
            prev_din <= din;
            if (rcnt == W_LAST) begin
              pd_pend  <= {prev_din, din};
              pend_vld <= 1'b1;
            end
          end
        end
        if (fall && in_frame) begin
          fcnt <= fnext;
          if (fnext == F_START) busy <= 1'b1;
          if (fnext == F_END) begin
            busy     <= 1'b0;
            done_cnt <= done_cnt + 1'b1;
            if (pend_vld) begin
              mode     <= pd_pend;
              pend_vld <= 1'b0;
            end
          end
          if (fnext == F_LOAD) shreg <= done_cnt;
          if (fnext > F_LOAD && fnext <= F_END) begin
            dout  <= shreg[RES_BITS-1];
            shreg <= {shreg[RES_BITS-2:0], 1'b0};
          end else begin
            dout <= 1'b0;
          end
          if (fnext == F_FRAME) in_frame <= 1'b0;
        end
      end
    end
  end

  assign conv_busy  = busy;
  assign conv_en    = busy | mode[1];
  assign pen_irq_n  = ~(pen_touch & ~mode[0] & ~busy);
  assign lowside_sw = ~conv_en & (mode == 2'b00);

  p_busy_masks_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> pen_irq_n);
  p_busy_powers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_busy |-> conv_en);
  p_sw_off_powered_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> !lowside_sw);
  p_cs_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !conv_busy && !dout);
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(mode));
  p_busy_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(fcnt) == F_START - 1'b1);
  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(cs_n) |-> $past(fcnt) == F_END - 1'b1);
endmodule

// File: tb/adc_pm_seq_tb.sv
module adc_pm_seq_tb;
  logic clk = 1'b0, rst_n, cs_n, sclk, din, pen_touch;
  logic conv_en, conv_busy, pen_irq_n, lowside_sw, dout;
  int checks = 0, fails = 0;
  logic [1:0] mode_m = 2'b00;
  logic [11:0] cnt_m = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  adc_pm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .pen_touch(pen_touch), .conv_en(conv_en), .conv_busy(conv_busy),
    .pen_irq_n(pen_irq_n), .lowside_sw(lowside_sw), .dout(dout)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic half();
    repeat (2) @(negedge clk);
  endtask

  task automatic rise(logic d);
    din = d; sclk = 1'b1; half();
  endtask

  task automatic fall();
    sclk = 1'b0; half();
  endtask

  task automatic check_outs(int n, logic [11:0] cnt0, bit b2b);
    logic busy_e, en_e, irq_e, sw_e, dout_e;
    busy_e = (n >= 4 && n < 20);
    en_e   = busy_e | mode_m[1];
    irq_e  = ~(pen_touch & ~mode_m[0] & ~busy_e);
    sw_e   = ~en_e & (mode_m == 2'b00);
    dout_e = (n >= 9 && n <= 20) ? cnt0[20-n] : 1'b0;
    if (n == 4 && b2b) chk("R12", "busy after back-to-back start", conv_busy, busy_e);
    else chk("R3", "conv_busy", conv_busy, busy_e);
    if (mode_m[1]) chk("R5", "conv_en", conv_en, en_e);
    else chk("R4", "conv_en", conv_en, en_e);
    chk("R7", "pen_irq_n", pen_irq_n, irq_e);
    chk("R8", "lowside_sw", lowside_sw, sw_e);
    chk("R11", "dout", dout, dout_e);
  endtask

  task automatic run_frame(logic [1:0] pd, logic [4:0] mid, int abort_at, bit b2b);
    logic [7:0] word;
    logic [11:0] cnt0;
    logic [1:0] old;
    word = {1'b1, mid, pd};
    cnt0 = cnt_m;
    old  = mode_m;
    for (int n = 1; n <= 24; n++) begin
      rise(n <= 8 ? word[8-n] : 1'b0);
      fall();
      if (n == 20) begin mode_m = pd; cnt_m = cnt_m + 1'b1; end
      check_outs(n, cnt0, b2b);
      if (n == 3) chk("R6", "old mode conv_en before commit", conv_en, old[1]);
      if (n == 21) chk("R6", "new mode irq after commit", pen_irq_n, ~(pen_touch & ~pd[0]));
      if (n == 24) chk("R2", "mode from last two bits", lowside_sw, pd == 2'b00);
      if (n == abort_at) begin
        cs_n = 1'b1; half();
        chk("R9", "busy after abort", conv_busy, 1'b0);
        chk("R9", "conv_en keeps old mode", conv_en, mode_m[1]);
        chk("R9", "dout after abort", dout, 1'b0);
        cs_n = 1'b0; half();
        return;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; pen_touch = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; half();
    chk("R10", "conv_en", conv_en, 1'b0);
    chk("R10", "conv_busy", conv_busy, 1'b0);
    chk("R10", "dout", dout, 1'b0);
    chk("R10", "lowside_sw", lowside_sw, 1'b1);
    chk("R10", "pen_irq_n touched", pen_irq_n, 1'b0);
    pen_touch = 1'b0; @(negedge clk);
    chk("R10", "pen_irq_n untouched", pen_irq_n, 1'b1);
    pen_touch = 1'b1;
    cs_n = 1'b0; half();

    for (int i = 0; i < 6; i++) begin
      rise(1'b0); fall();
      chk("R1", "busy with zero bits", conv_busy, 1'b0);
      chk("R1", "conv_en with zero bits", conv_en, 1'b0);
    end

    for (int o = 0; o < 4; o++)
      for (int w = 0; w < 4; w++) begin
        pen_touch = ((o * 4 + w) % 3) != 0;
        run_frame(2'(o), 5'(o * 7 + w * 3), 0, 1'b1);
        run_frame(2'(w), 5'(o * 5 + w * 11 + 9), 0, 1'b1);
      end

    pen_touch = 1'b1;
    run_frame(2'b00, 5'd3, 0, 1'b1);
    run_frame(2'b11, 5'd21, 10, 1'b1);
    run_frame(2'b01, 5'd12, 0, 1'b0);
    run_frame(2'b10, 5'd30, 0, 1'b1);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule